// File: doc/BRIEF.md
# Streaming Separable Gaussian Smoother

This block blurs an 8-bit grayscale frame that sits in an on-chip memory. It runs two passes with the same 9-tap kernel. The first pass is vertical, down each column. The second is horizontal, along each row. Both passes work at the same time. Each vertical result goes straight into a nine-entry shift chain. The horizontal pass reads that chain. No intermediate frame is stored.

The image memory is split into nine lanes. Each lane returns one pixel, one cycle after it is addressed, so a whole 9-pixel column arrives in one read. After a single `start` pulse, the block scans the frame in row-major order. It emits one filtered pixel on a valid-qualified stream and raises a one-cycle done flag on the last pixel. Kernel weights are written one tap at a time through a small load port while the block is idle.

A sequencer state machine drives the scan. Its states are:
- **IDLE**: waiting. It moves to FETCH when `start` arrives.
- **FETCH**: issues one column read. It always moves to WAIT.
- **WAIT**: the spacer cycle. It returns to FETCH while columns remain, and moves to DRAIN after the frame's last column has been issued.
- **DRAIN**: lets the eight-stage pipeline empty. It returns to IDLE after eight cycles.

Each row takes W+4 column steps. The last four steps are zero columns that flush the chain, and they also give the next row its zero left margin.

Top module: `gauss_sep_conv`

## Requirements
- R1: After reset, `pix_valid`, `frame_done` and `rd_en` are low, and they stay low until `start` is given.
- R2: A write with `coef_we` high and `coef_idx` in 0..8 sets tap `coef_idx` while idle. Tap 0 weights the sample four rows above (vertical pass) or four columns left (horizontal pass) of the centre. Tap 8 weights offset +4.
- R3: The vertical result at (y,x) is floor(sum over i of c[i]·p(y+i-4,x) / S), limited to 255. S is the sum of all nine taps.
- R4: The output at (y,x) is floor(sum over j of c[j]·v(y,x+j-4) / S), limited to 255. The v values are the R3 results, and the same taps are used.
- R5: Samples outside the frame count as zero. Exactly W·H pixels are emitted per frame, in row-major order (default 48x48).
- R6: Within a row, consecutive output pixels are exactly two cycles apart. `pix_valid` is never high on two adjacent cycles.
- R7: `frame_done` is high for exactly one cycle per frame, together with the valid final pixel.
- R8: A `start` pulse while a frame is in progress has no effect. No second frame and no extra pixels follow.
- R9: Tap writes while a frame is in progress are ignored, both for that frame and for later frames.
- R10: If S is zero, every output pixel is 0.
- R11: `rd_en` is high for one cycle per column step, never on two adjacent cycles. Lane i then addresses (y+i-4)·W+x, always within 0..W·H-1, and its data is taken one cycle later on `rd_data` lane i (bits 8i+7:8i).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts one frame when idle |
| coef_we | input | 1 | Tap write strobe |
| coef_idx | input | 4 | Tap index 0..8 |
| coef_data | input | 8 | Tap weight |
| rd_en | output | 1 | Column read strobe to the image memory |
| rd_addr | output | 9·AW | Nine lane addresses; lane i is at bits AW·i+AW-1:AW·i |
| rd_data | input | 72 | Nine lane pixels, returned one cycle after `rd_en` |
| pix_valid | output | 1 | Output pixel qualifier |
| pix_out | output | 8 | Filtered pixel |
| frame_done | output | 1 | One-cycle pulse with the last pixel |

## Verification
The embedded properties assume three things about the environment:
- the memory answers every lane read on the next cycle;
- taps are written only through the load port;
- `start` is a single-cycle pulse.

The bench models the memory as nine registered lanes over one image array, and it keeps `start` to one cycle. In the two stall tests it raises the stray `start` and the tap writes mid-frame on purpose. It then judges their absence of effect from the emitted pixels and from a later frame.

// File: rtl/gconv_pkg.sv
package gconv_pkg;
    localparam int unsigned KT         = 9;
    localparam int unsigned HALF       = KT / 2;
    localparam int unsigned PW         = 8;
    localparam int unsigned CW         = 8;
    localparam int unsigned CSW        = CW + $clog2(KT);
    localparam int unsigned PIPE_DEPTH = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_DRAIN
    } seq_state_e;

    typedef struct packed {
        logic          vld;
        logic          emit;
        logic          last;
        logic [KT-1:0] pad;
    } tok_t;
endpackage

// File: rtl/gconv_seq.sv
module gconv_seq
    import gconv_pkg::*;
#(
    parameter int unsigned W  = 48,
    parameter int unsigned H  = 48,
    parameter int unsigned AW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             rd_en,
    output logic [KT*AW-1:0] rd_addr,
    output tok_t             tok
);
    localparam int unsigned STEPS = W + HALF;
    localparam int unsigned KW    = $clog2(STEPS + 1);
    localparam int unsigned RW    = $clog2(H + 1);
    localparam int unsigned DW    = $clog2(PIPE_DEPTH + 1);

    seq_state_e      state_q, state_d;
    logic [KW-1:0]   col_q;
    logic [RW-1:0]   row_q;
    logic            last_q;
    logic [DW-1:0]   drn_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_WAIT;
            ST_WAIT:  state_d = last_q ? ST_DRAIN : ST_FETCH;
            ST_DRAIN: if (drn_q == DW'(PIPE_DEPTH - 1)) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            col_q   <= '0;
            row_q   <= '0;
            last_q  <= 1'b0;
            drn_q   <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    col_q  <= '0;
                    row_q  <= '0;
                    last_q <= 1'b0;
                    drn_q  <= '0;
                end
                ST_FETCH: begin
                    if (col_q == KW'(STEPS - 1)) begin
                        col_q <= '0;
                        row_q <= row_q + 1'b1;
                        if (row_q == RW'(H - 1)) last_q <= 1'b1;
                    end else begin
                        col_q <= col_q + 1'b1;
                    end
                end
                ST_WAIT:  ;
                ST_DRAIN: drn_q <= drn_q + 1'b1;
                default:  ;
            endcase
        end
    end

    always_comb begin
        busy     = (state_q != ST_IDLE);
        rd_en    = (state_q == ST_FETCH);
        tok.vld  = rd_en;
        tok.emit = (int'(col_q) >= int'(HALF));
        tok.last = tok.emit && (row_q == RW'(H - 1)) && (col_q == KW'(STEPS - 1));
        for (int i = 0; i < int'(KT); i++) begin
            int r;
            r = int'(row_q) + i - int'(HALF);
            tok.pad[i] = (r < 0) || (r >= int'(H)) || (int'(col_q) >= int'(W));
            rd_addr[i*AW +: AW] = tok.pad[i] ? '0 : AW'(r * int'(W) + int'(col_q));
        end
    end

    // R11
    rd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && start) |=> (state_q == ST_WAIT));

    for (genvar g = 0; g < int'(KT); g++) begin : g_lane_chk
        // R11
        addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en |-> (int'(rd_addr[g*AW +: AW]) < int'(W * H)));
    end
endmodule

// File: rtl/gconv_mac.sv
module gconv_mac
    import gconv_pkg::*;
#(
    parameter int unsigned OPW = 8
) (
    input  logic              clk,
    input  logic [KT*OPW-1:0] opnd,
    input  logic [KT*CW-1:0]  coef,
    input  logic [CSW-1:0]    csum,
    output logic [PW-1:0]     res
);
    localparam int unsigned PRW = OPW + CW;
    localparam int unsigned SW  = PRW + $clog2(KT);

    logic [PRW-1:0] prod_q [KT];
    logic [SW-1:0]  acc, sum_q, quo;
    logic [PW-1:0]  res_q;

    for (genvar g = 0; g < int'(KT); g++) begin : g_mul
        always_ff @(posedge clk)
            prod_q[g] <= PRW'(opnd[g*OPW +: OPW]) * PRW'(coef[g*CW +: CW]);
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < int'(KT); i++) acc = acc + SW'(prod_q[i]);
    end

    always_ff @(posedge clk) sum_q <= acc;

    always_comb quo = (csum == '0) ? '0 : sum_q / SW'(csum);

    always_ff @(posedge clk) begin
        if (csum == '0)                       res_q <= '0;
        else if (quo > SW'((1 << PW) - 1))    res_q <= '1;
        else                                  res_q <= quo[PW-1:0];
    end

    assign res = res_q;
endmodule

// File: rtl/gauss_sep_conv.sv
module gauss_sep_conv
    import gconv_pkg::*;
#(
    parameter int unsigned W = 48,
    parameter int unsigned H = 48,
    localparam int unsigned AW = $clog2(W * H),
    localparam int unsigned IW = $clog2(KT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             coef_we,
    input  logic [IW-1:0]    coef_idx,
    input  logic [CW-1:0]    coef_data,
    output logic             rd_en,
    output logic [KT*AW-1:0] rd_addr,
    input  logic [KT*PW-1:0] rd_data,
    output logic             pix_valid,
    output logic [PW-1:0]    pix_out,
    output logic             frame_done
);
    logic              busy;
    tok_t              issue_tok;
    tok_t              tk [1:PIPE_DEPTH];
    logic [KT*CW-1:0]  coef_q;
    logic [CSW-1:0]    csum;
    logic [KT*PW-1:0]  v_op;
    logic [PW-1:0]     v_res, h_res;
    logic [KT*PW-1:0]  chain_q;

    gconv_seq #(.W(W), .H(H), .AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
        .rd_en(rd_en), .rd_addr(rd_addr), .tok(issue_tok)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) coef_q <= '0;
        else if (coef_we && !busy && int'(coef_idx) < int'(KT))
            coef_q[int'(coef_idx)*CW +: CW] <= coef_data;
    end

    always_comb begin
        csum = '0;
        for (int i = 0; i < int'(KT); i++) csum = csum + CSW'(coef_q[i*CW +: CW]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 1; n <= int'(PIPE_DEPTH); n++) tk[n] <= '0;
        end else begin
            tk[1] <= issue_tok;
            for (int n = 2; n <= int'(PIPE_DEPTH); n++) tk[n] <= tk[n-1];
        end
    end

    always_comb begin
        for (int i = 0; i < int'(KT); i++)
            v_op[i*PW +: PW] = tk[1].pad[i] ? '0 : rd_data[i*PW +: PW];
    end

    gconv_mac #(.OPW(PW)) u_vmac (
        .clk(clk), .opnd(v_op), .coef(coef_q), .csum(csum), .res(v_res)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         chain_q <= '0;
        else if (tk[4].vld) chain_q <= {v_res, chain_q[KT*PW-1:PW]};
    end

    gconv_mac #(.OPW(PW)) u_hmac (
        .clk(clk), .opnd(chain_q), .coef(coef_q), .csum(csum), .res(h_res)
    );

    assign pix_valid  = tk[PIPE_DEPTH].vld && tk[PIPE_DEPTH].emit;
    assign frame_done = tk[PIPE_DEPTH].vld && tk[PIPE_DEPTH].last;
    assign pix_out    = h_res;

    // R6
    no_backtoback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> !pix_valid);

    // R7
    done_with_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> pix_valid);

    // R9
    coef_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(coef_q));

    // R1
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !tk[PIPE_DEPTH].vld) |-> (!pix_valid && !frame_done && !rd_en));
endmodule

// File: tb/tb_gauss_sep_conv.sv
`timescale 1ns/1ps
module tb_gauss_sep_conv;
    import gconv_pkg::*;

    localparam int W    = 48;
    localparam int H    = 48;
    localparam int NPIX = W * H;
    localparam int AW   = $clog2(NPIX);
    localparam int IW   = $clog2(KT);

    localparam logic [71:0] K_GAUSS = {8'd2, 8'd8, 8'd22, 8'd48, 8'd100, 8'd48, 8'd22, 8'd8, 8'd2};
    localparam logic [71:0] K_ASYM  = {8'd0, 8'd0, 8'd30, 8'd100, 8'd50, 8'd0, 8'd0, 8'd0, 8'd10};
    localparam logic [71:0] K_IDENT = {8'd0, 8'd0, 8'd0, 8'd0, 8'd1, 8'd0, 8'd0, 8'd0, 8'd0};
    localparam logic [71:0] K_BOX   = {9{8'd1}};

    // stimulus table: {pattern id, kernel taps with tap 0 in the low byte}
    localparam int NCASE = 5;
    localparam logic [79:0] CASES [NCASE] = '{
        {8'd0, K_GAUSS},
        {8'd2, K_GAUSS},
        {8'd2, K_ASYM},
        {8'd1, K_IDENT},
        {8'd3, K_BOX}
    };

    logic             clk, rst_n, start, coef_we;
    logic [IW-1:0]    coef_idx;
    logic [7:0]       coef_data;
    logic             rd_en;
    logic [KT*AW-1:0] rd_addr;
    logic [KT*8-1:0]  rd_data;
    logic             pix_valid, frame_done;
    logic [7:0]       pix_out;

    gauss_sep_conv #(.W(W), .H(H)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .coef_we(coef_we),
        .coef_idx(coef_idx), .coef_data(coef_data), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .pix_valid(pix_valid),
        .pix_out(pix_out), .frame_done(frame_done)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    int nchk = 0, nfail = 0;
    logic [7:0] img [NPIX];
    int vbuf [NPIX];
    int expv [NPIX];
    int obuf [NPIX];
    int ocyc [NPIX];
    int ocnt = 0, dcnt = 0, didx = -1, cyc = 0;
    bit finished = 1'b0;

    always @(posedge clk) begin
        if (rd_en) begin
            for (int i = 0; i < KT; i++) begin
                int a;
                a = int'(rd_addr[i*AW +: AW]);
                rd_data[i*8 +: 8] <= (a < NPIX) ? img[a] : 8'd0;
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (pix_valid) begin
            if (ocnt < NPIX) begin
                obuf[ocnt] = int'(pix_out);
                ocyc[ocnt] = cyc;
            end
            ocnt++;
        end
        if (frame_done) begin
            dcnt++;
            didx = ocnt - 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp_v);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    function automatic int patv(input int p, input int x, input int y);
        case (p)
            0:       return (x * 5 + y * 3) & 255;
            1:       return ((x ^ y) & 1) ? 255 : 0;
            2:       return (x * 37 + y * 91 + x * y * 13) & 255;
            default: return 200;
        endcase
    endfunction

    task automatic fill(input int p);
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) img[y*W + x] = 8'(patv(p, x, y));
    endtask

    task automatic model(input logic [71:0] k);
        int s;
        s = 0;
        for (int i = 0; i < KT; i++) s += int'(k[i*8 +: 8]);
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) begin
                int acc;
                acc = 0;
                for (int i = 0; i < KT; i++) begin
                    int r;
                    r = y + i - HALF;
                    if (r >= 0 && r < H) acc += int'(k[i*8 +: 8]) * int'(img[r*W + x]);
                end
                vbuf[y*W + x] = (s == 0) ? 0 : ((acc / s > 255) ? 255 : acc / s);
            end
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) begin
                int acc;
                acc = 0;
                for (int j = 0; j < KT; j++) begin
                    int c;
                    c = x + j - HALF;
                    if (c >= 0 && c < W) acc += int'(k[j*8 +: 8]) * vbuf[y*W + c];
                end
                expv[y*W + x] = (s == 0) ? 0 : ((acc / s > 255) ? 255 : acc / s);
            end
    endtask

    task automatic load(input logic [71:0] k);
        for (int i = 0; i < KT; i++) begin
            coef_we = 1'b1; coef_idx = IW'(i); coef_data = k[i*8 +: 8];
            @(posedge clk); #1;
        end
        coef_we = 1'b0;
    endtask

    // mode 0: plain, 1: stray start mid-frame, 2: tap writes mid-frame
    task automatic run_frame(input int mode);
        ocnt = 0; dcnt = 0; didx = -1;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        for (int n = 0; n < 20000 && dcnt == 0; n++) begin
            if (mode == 1 && n == 300) start = 1'b1;
            if (mode == 1 && n == 301) start = 1'b0;
            if (mode == 2 && n == 300) begin coef_we = 1'b1; coef_idx = 4'd4; coef_data = 8'd0; end
            if (mode == 2 && n == 301) begin coef_idx = 4'd0; coef_data = 8'd200; end
            if (mode == 2 && n == 302) coef_we = 1'b0;
            @(posedge clk); #1;
        end
        check(dcnt != 0, "R7 frame never completed", dcnt, 1);
        repeat (60) @(posedge clk);
        #1;
    endtask

    task automatic verify();
        int bad_gap;
        check(ocnt == NPIX, "R5 pixel count", ocnt, NPIX);
        check(dcnt == 1, "R7 done pulse count", dcnt, 1);
        check(didx == NPIX - 1, "R7 done on last pixel", didx, NPIX - 1);
        for (int i = 0; i < NPIX && i < ocnt; i++) begin
            int x, y;
            x = i % W; y = i / W;
            if (x < HALF || y < HALF || x >= W - HALF || y >= H - HALF)
                check(obuf[i] == expv[i], $sformatf("R5 border pixel %0d", i), obuf[i], expv[i]);
            else
                check(obuf[i] == expv[i], $sformatf("R3,R4 pixel %0d", i), obuf[i], expv[i]);
        end
        bad_gap = 0;
        for (int i = 1; i < NPIX && i < ocnt; i++)
            if ((i % W) != 0 && ocyc[i] - ocyc[i-1] != 2) bad_gap++;
        check(bad_gap == 0, "R6 in-row spacing violations", bad_gap, 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; coef_we = 1'b0; coef_idx = '0; coef_data = '0;
        rd_data = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        // R1 reset state
        check(!pix_valid, "R1 pix_valid after reset", int'(pix_valid), 0);
        check(!frame_done, "R1 frame_done after reset", int'(frame_done), 0);
        check(!rd_en, "R1 rd_en after reset", int'(rd_en), 0);
        check(ocnt == 0, "R1 no output before start", ocnt, 0);

        // table walk: R2 tap order, R3/R4 arithmetic, R5 borders, R11 addressing
        for (int c = 0; c < NCASE; c++) begin
            fill(int'(CASES[c][79:72]));
            load(CASES[c][71:0]);
            model(CASES[c][71:0]);
            run_frame(0);
            verify();
        end

        // R8 stray start during a frame
        fill(2); load(K_GAUSS); model(K_GAUSS);
        run_frame(1);
        verify();
        check(ocnt == NPIX, "R8 no extra pixels after stray start", ocnt, NPIX);
        check(!rd_en && !pix_valid, "R8 block idle after frame", int'(rd_en), 0);

        // R9 tap writes during a frame are dropped, now and later
        fill(0); load(K_IDENT); model(K_IDENT);
        run_frame(2);
        verify();
        run_frame(0);
        verify();
        check(obuf[W + 1] == int'(img[W + 1]), "R9 identity kept after dropped writes",
              obuf[W + 1], int'(img[W + 1]));

        // R10 zero tap sum
        fill(3); load('0); model('0);
        run_frame(0);
        verify();
        check(obuf[NPIX / 2] == 0, "R10 zero-sum output", obuf[NPIX / 2], 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule